// File: doc/BRIEF.md
# Palette colour table with byte-wide register port

This block sits between an 8-bit processor bus and the pixel path of a display controller. It holds a 256-entry colour table with red, green and blue bytes per entry. Software fills it by loading a start index and then writing bytes, which land in the order red, green, blue. The index steps forward by itself after each blue byte, so a whole table can be streamed after a single index load.

Software reads the table back the same way. A build-time choice decides whether readback has its own start index and component counter, or shares the ones used for writing. An 8-bit pixel mask is ANDed with each incoming pixel code. The masked code selects an entry, and the entry comes out on a 24-bit colour bus one clock later. A second build-time choice treats the stored bytes as 6-bit intensities and widens them to 8 bits on the way out.

Internally the table is addressed as component number above index (`{component, index}`), with red as component 0, green as 1 and blue as 2.

Top module: `pal_regport`

## Requirements
- R1: After reset, reading register 0 (write index) returns 0x00, register 3 (read index) returns 0x00 and register 2 (mask) returns 0xFF. The component counters start at 0 (red).
- R2: Writing register 0 loads the write index and resets the write component counter to red. The following data writes (register 1) store red, green and blue of that entry, in that order.
- R3: Each data access steps the component counter of the pointer it used. After blue the counter returns to red and the index of that pointer rises by one, wrapping from 0xFF to 0x00. A partial triplet leaves the index unchanged.
- R4: With SPLIT_READ=1, writing register 3 loads the read index and clears the read counter. Data reads then return the entry's components in red, green, blue order from the read pointer and advance only that pointer. Each byte is the one at the address before the step, and the write index is not disturbed.
- R5: With SPLIT_READ=0, data reads take their address from the write pointer and advance it.
- R6: Reading register 0 returns the current write index, including after automatic steps. Reading register 3 returns the read index.
- R7: Register 2 holds the pixel mask, and writes to it read back unchanged. The colour output presents entry (pix_in AND mask) as {red[23:16], green[15:8], blue[7:0]}, registered one clock after pix_in.
- R8: With SIX_BIT=1, each output component is {v[5:0], v[5:4]} of the stored byte v, for example 0x3F gives 0xFF and 0x20 gives 0x82. With SIX_BIT=0, the stored byte is output unchanged. Data reads always return the stored byte.
- R9: Read data (rdata) is registered: it appears one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select: 0 write index, 1 data, 2 mask, 3 read index |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pix_in | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Looked-up colour, red in the top byte |

## Verification
The checker assumes the bus never asserts the read and write strobes in the same cycle, so a shared pointer is never stepped twice at once; it flags a violation of that rule. The component counters are assumed to stay within red..blue, which only holds if the counters are changed by the register accesses alone. The bench drives each access as a one-cycle strobe and never overlaps a read with a write. It reads only table entries it has written, so no check depends on uninitialised storage. Two instances with opposite build choices see the same bus traffic, and each is compared against its own model.

// File: rtl/pal_regport.sv
module pal_regport #(
  parameter bit SPLIT_READ = 1'b1,
  parameter bit SIX_BIT    = 1'b0,
  parameter int IW         = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  pix_in,
  output logic [23:0] pix_rgb
);
  localparam int DEPTH = 1 << IW;
  localparam int AW    = IW + 2;

  logic [7:0]    mem [0:4*DEPTH-1];
  logic [IW-1:0] widx, ridx, mask;
  logic [1:0]    wcomp, rcomp;

  wire dwr   = wr_en && (sel == 2'd1);
  wire drd   = rd_en && (sel == 2'd1);
  wire w_adv = dwr || (drd && !SPLIT_READ);
  wire r_adv = drd && SPLIT_READ;

  wire [AW-1:0] waddr = {wcomp, widx};
  wire [AW-1:0] raddr = SPLIT_READ ? {rcomp, ridx} : {wcomp, widx};
  wire [IW-1:0] pidx  = pix_in[IW-1:0] & mask;

  function automatic logic [7:0] widen(input logic [7:0] v);
    return SIX_BIT ? {v[5:0], v[5:4]} : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx  <= '0;
      wcomp <= 2'd0;
    end else if (wr_en && sel == 2'd0) begin
      widx  <= wdata[IW-1:0];
      wcomp <= 2'd0;
    end else if (w_adv) begin
      if (wcomp == 2'd2) begin
        wcomp <= 2'd0;
        widx  <= widx + 1'b1;
      end else begin
        wcomp <= wcomp + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ridx  <= '0;
      rcomp <= 2'd0;
    end else if (wr_en && sel == 2'd3) begin
      ridx  <= wdata[IW-1:0];
      rcomp <= 2'd0;
    end else if (r_adv) begin
      if (rcomp == 2'd2) begin
        rcomp <= 2'd0;
        ridx  <= ridx + 1'b1;
      end else begin
        rcomp <= rcomp + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       mask <= '1;
    else if (wr_en && sel == 2'd2)    mask <= wdata[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (dwr) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= 8'h00;
    end else if (rd_en) begin
      case (sel)
        2'd0:    rdata <= 8'(widx);
        2'd1:    rdata <= mem[raddr];
        2'd2:    rdata <= 8'(mask);
        default: rdata <= 8'(ridx);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= 24'h0;
    else        pix_rgb <= {widen(mem[{2'd0, pidx}]),
                            widen(mem[{2'd1, pidx}]),
                            widen(mem[{2'd2, pidx}])};
  end
endmodule

// File: rtl/pal_regport_chk.sv
module pal_regport_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sel,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    wdata,
  input logic [IW-1:0] widx,
  input logic [1:0]    wcomp,
  input logic [IW-1:0] ridx,
  input logic [1:0]    rcomp
);
  // R5: a shared pointer must not be stepped by a read and a write at once
  p_no_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  p_comp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wcomp != 2'd3) && (rcomp != 2'd3));

  p_widx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0) |=> (widx == $past(wdata[IW-1:0]) && wcomp == 2'd0));

  p_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd1 && wcomp == 2'd2) |=>
      (wcomp == 2'd0 && widx == $past(widx) + 1'b1));

  p_ridx_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd3) |=> (ridx == $past(wdata[IW-1:0]) && rcomp == 2'd0));

  p_wr_keeps_rptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd1) |=> ($stable(ridx) && $stable(rcomp)));
endmodule

bind pal_regport pal_regport_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .widx(widx), .wcomp(wcomp), .ridx(ridx), .rcomp(rcomp)
);

// File: tb/tb_pal_regport.sv
module tb_pal_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00, pix_in = 8'h00;
  logic [7:0] rdata_a, rdata_b;
  logic [23:0] pix_a, pix_b;

  always #4 clk = ~clk;

  pal_regport #(.SPLIT_READ(1'b1), .SIX_BIT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata_a), .pix_in(pix_in), .pix_rgb(pix_a));

  pal_regport #(.SPLIT_READ(1'b0), .SIX_BIT(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata_b), .pix_in(pix_in), .pix_rgb(pix_b));

  int total = 0, bad = 0;

  // model state, [0] = split/8-bit instance, [1] = shared/6-bit instance
  logic [7:0] pm [2][0:1023];
  int widx [2], wc [2], ridx [2], rc [2], msk [2];
  bit split [2] = '{1'b1, 1'b0};

  typedef struct packed { logic pix; logic [23:0] ea; logic [23:0] eb; } exp_t;
  exp_t  q_exp [$];
  string q_tag [$];
  logic chk_now = 1'b0, chk_q = 1'b0;

  function automatic logic [7:0] widen(input logic [7:0] v);
    return {v[5:0], v[5:4]};
  endfunction

  task automatic step(inout int idx, inout int c);
    c++;
    if (c == 3) begin c = 0; idx = (idx + 1) % 256; end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    sel = s; wdata = d; wr_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      case (s)
        2'd0: begin widx[k] = d; wc[k] = 0; end
        2'd1: begin pm[k][wc[k]*256 + widx[k]] = d; step(widx[k], wc[k]); end
        2'd2: msk[k] = d;
        default: begin ridx[k] = d; rc[k] = 0; end
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input string tag);
    logic [7:0] e [2];
    exp_t x;
    for (int k = 0; k < 2; k++) begin
      case (s)
        2'd0: e[k] = 8'(widx[k]);
        2'd2: e[k] = 8'(msk[k]);
        2'd3: e[k] = 8'(ridx[k]);
        default:
          if (split[k]) begin
            e[k] = pm[k][rc[k]*256 + ridx[k]]; step(ridx[k], rc[k]);
          end else begin
            e[k] = pm[k][wc[k]*256 + widx[k]]; step(widx[k], wc[k]);
          end
      endcase
    end
    x.pix = 1'b0; x.ea = {16'h0, e[0]}; x.eb = {16'h0, e[1]};
    q_exp.push_back(x); q_tag.push_back(tag);
    sel = s; rd_en = 1'b1; chk_now = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; chk_now = 1'b0;
  endtask

  task automatic pix(input logic [7:0] p, input string tag);
    exp_t x;
    int i0, i1;
    i0 = p & msk[0]; i1 = p & msk[1];
    x.pix = 1'b1;
    x.ea = {pm[0][i0], pm[0][256 + i0], pm[0][512 + i0]};
    x.eb = {widen(pm[1][i1]), widen(pm[1][256 + i1]), widen(pm[1][512 + i1])};
    q_exp.push_back(x); q_tag.push_back(tag);
    pix_in = p; chk_now = 1'b1;
    @(negedge clk);
    chk_now = 1'b0;
  endtask

  always @(posedge clk) chk_q <= chk_now;

  always @(negedge clk) begin
    if (chk_q) begin
      exp_t x;
      string t;
      logic [23:0] aa, ab;
      if (q_exp.size() == 0) begin
        total++; bad++;
        $display("FAIL monitor: result with empty queue act=%h exp=none", rdata_a);
      end else begin
        x = q_exp.pop_front(); t = q_tag.pop_front();
        aa = x.pix ? pix_a : {16'h0, rdata_a};
        ab = x.pix ? pix_b : {16'h0, rdata_b};
        total++;
        if (aa !== x.ea) begin
          bad++; $display("FAIL %s split inst act=%h exp=%h", t, aa, x.ea);
        end
        total++;
        if (ab !== x.eb) begin
          bad++; $display("FAIL %s shared inst act=%h exp=%h", t, ab, x.eb);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      widx[k] = 0; wc[k] = 0; ridx[k] = 0; rc[k] = 0; msk[k] = 8'hFF;
      for (int a = 0; a < 1024; a++) pm[k][a] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, "R1"); rd(2'd2, "R1"); rd(2'd3, "R1");

    // fill entries 0..31
    wr(2'd0, 8'h00);
    for (int i = 0; i < 32; i++)
      for (int c = 0; c < 3; c++) wr(2'd1, 8'(i * 7 + c * 83 + 5));
    rd(2'd0, "R6");

    // R2 index load then triplet
    wr(2'd0, 8'h10);
    wr(2'd1, 8'hC3); wr(2'd1, 8'h3F); wr(2'd1, 8'h20);
    rd(2'd0, "R6");
    pix(8'h10, "R2");

    // R3 wrap from 0xFF
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    rd(2'd0, "R3");
    pix(8'hFF, "R3");
    // R3 partial triplet keeps index, reload clears counter
    wr(2'd0, 8'h05);
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
    rd(2'd0, "R3");
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
    pix(8'h05, "R3");

    // R4 separate read pointer (R5 for the shared instance)
    wr(2'd0, 8'h02);
    wr(2'd3, 8'h10);
    rd(2'd3, "R6");
    rd(2'd1, "R4"); rd(2'd1, "R4"); rd(2'd1, "R4"); rd(2'd1, "R4");
    rd(2'd0, "R5");
    rd(2'd3, "R4");

    // R5 shared read from write pointer
    wr(2'd0, 8'h10);
    rd(2'd1, "R5"); rd(2'd1, "R5"); rd(2'd1, "R5");
    rd(2'd0, "R5");

    // R4 reads mid-triplet then index load from write side untouched
    wr(2'd3, 8'h07);
    rd(2'd1, "R4");
    wr(2'd0, 8'h08);
    rd(2'd1, "R4"); rd(2'd1, "R4");
    rd(2'd3, "R4");

    // R7 mask and lookup, R8 widening
    for (int i = 0; i < 32; i++) pix(8'(i), "R8");
    wr(2'd2, 8'h0F);
    rd(2'd2, "R7");
    pix(8'h1F, "R7"); pix(8'hF3, "R7"); pix(8'h10, "R7");
    wr(2'd2, 8'hFF);
    pix(8'h10, "R8");

    // R9 rdata holds between reads
    rd(2'd2, "R9");
    begin
      exp_t x;
      x.pix = 1'b0; x.ea = 24'hFF; x.eb = 24'hFF;
      q_exp.push_back(x); q_tag.push_back("R9");
      chk_now = 1'b1; sel = 2'd0;
      @(negedge clk);
      chk_now = 1'b0;
    end

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      total++; bad++;
      $display("FAIL monitor: pending act=%0d exp=0", q_exp.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule